// File: doc/BRIEF.md
# Weighted Slot Issue Scheduler with Shared-Memory Stall

This block decides, every clock, which of up to four hardware threads may issue into a single in-order pipeline that all of them share. A sixteen-entry table of issue slots, each naming a thread, sets the order. Giving a thread several entries gives it a larger share of issue cycles. A pointer walks the table. Entries whose thread has nothing ready are passed over within the same cycle, so a ready thread never waits behind an idle one.

Ordinary instructions complete in the cycle they issue. A shared-memory instruction has to wait for an access window that a free-running phase counter opens once every eight clocks. While such an access is outstanding the whole pipeline is frozen. No thread issues and the table pointer holds. The scheduler reports each issue decision, a stall flag, and a retire pulse tagged with the thread that finished. A thread stub drives the ready and memory-op flags, and a test harness uses the retire pulses to measure slot shares and stall lengths.

All outputs are registered. Each output reflects the decision made from the inputs present in the cycle before it.

Top module: `hss_sched`

## Requirements
- R1: While reset is high, all outputs are zero. After reset the slot table holds entry i = thread (i mod 4), the pointer is at entry 0 and the window counter is 0 in the first cycle, so with all threads ready the issue order is 0, 1, 2, 3, 0, ...
- R2: In a cycle with no outstanding memory access, the scan starts at the pointer and walks the entries in table order, wrapping after entry 15. The first entry whose thread has its ready bit set issues in that cycle. If no thread is ready, nothing issues and `issue_vld` stays 0. When nothing issues, `issue_tid` reads 0.
- R3: After an issue, the pointer moves to the entry after the one that issued, wrapping from 15 to 0. It does not move in a stalled cycle or in a cycle where nothing issues.
- R4: Writing the repeating pattern 1, 0, 1, 2 into the table with threads 0 to 2 ready gives thread 1 exactly 32 of every 64 issue cycles, and threads 0 and 2 16 each.
- R5: An instruction whose memory-op flag is clear retires in the cycle it issues. `retire_vld` is high and `retire_tid` equals `issue_tid`. When nothing retires, `retire_tid` reads 0.
- R6: A 3-bit counter advances every cycle and marks a window when it reads 0. A memory op issued in cycle k retires 2 cycles after the first window at or after k. Its latency is 3 cycles when it issues on a window and 10 when it issues one cycle after one.
- R7: From the cycle after a memory op issues through its retire cycle, `stall` is high and no thread issues, whatever the ready bits show. `stall` drops in the cycle after the retire.
- R8: With all four threads issuing memory ops back to back and the first one issued one cycle past a window, the retire gaps are 10, 8, 8 and 8 cycles, 34 cycles from the first issue to the fourth retire.
- R9: A table write takes effect at the clock edge that ends its cycle. A scan in the same cycle still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_addr | input | 4 | Slot table entry to write |
| tbl_tid | input | 2 | Thread number stored in the entry |
| thr_valid | input | 4 | Per-thread instruction-ready flags |
| thr_hub | input | 4 | Per-thread flag: the ready instruction is a shared-memory op |
| issue_vld | output | 1 | A thread issued in the previous decision cycle |
| issue_tid | output | 2 | Thread that issued |
| issue_hub | output | 1 | The issued instruction is a shared-memory op |
| stall | output | 1 | Pipeline frozen by an outstanding memory access |
| retire_vld | output | 1 | One-cycle retire pulse |
| retire_tid | output | 2 | Thread that retired |

## Verification
A table write and the slot scan can land in the same cycle, even on the entry the pointer is reading. The bench provokes this on purpose: it rewrites the entry under the pointer while the old owner is the only ready thread. The issue must name the old owner. Random traffic also writes the table at random moments while threads issue and stall. A cycle-level model in the bench applies every write only after its own scan, so any early or late update shows up as a mismatch in the issued thread.

// File: rtl/hss_pkg.sv
package hss_pkg;

  // shared-memory access sequencer states
  typedef enum logic [1:0] {
    HUB_IDLE = 2'd0,
    HUB_WAIT = 2'd1,
    HUB_XFER = 2'd2
  } hub_state_e;

endpackage

// File: rtl/hss_slot_table.sv
module hss_slot_table #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 16,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_addr,
  input  logic [TID_W-1:0]              wr_tid,
  output logic [NUM_SLOTS*TID_W-1:0]    entries_flat
);

  logic [TID_W-1:0] ent [NUM_SLOTS];

  // reset loads a plain rotation over the threads
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++)
        ent[i] <= TID_W'(i % NUM_THREADS);
    end else if (wr_en) begin
      ent[wr_addr] <= wr_tid;
    end
  end

  // every entry is visible at once for the single-cycle scan
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
    assign entries_flat[g*TID_W +: TID_W] = ent[g];
  end

endmodule

// File: rtl/hss_slot_pick.sv
module hss_slot_pick #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 16,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*TID_W-1:0] entries_flat,
  input  logic [SLOT_W-1:0]          ptr,
  input  logic [NUM_THREADS-1:0]     thr_valid,
  output logic                       found,
  output logic [SLOT_W-1:0]          pick_slot,
  output logic [TID_W-1:0]           pick_tid
);

  logic [NUM_SLOTS-1:0] rot_hit;
  logic [SLOT_W-1:0]    rot_slot [NUM_SLOTS];
  logic [TID_W-1:0]     rot_tid  [NUM_SLOTS];

  // view of the table rotated so that offset 0 is the pointer
  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_rot
    logic [SLOT_W:0] sum;
    assign sum = {1'b0, ptr} + (SLOT_W+1)'(j);
    assign rot_slot[j] = (sum >= (SLOT_W+1)'(NUM_SLOTS)) ?
                         SLOT_W'(sum - (SLOT_W+1)'(NUM_SLOTS)) : sum[SLOT_W-1:0];
    assign rot_tid[j]  = entries_flat[rot_slot[j]*TID_W +: TID_W];
    assign rot_hit[j]  = (32'(rot_tid[j]) < NUM_THREADS) && thr_valid[rot_tid[j]];
  end

  // lowest offset wins: walk from the far end so the nearest hit is last
  always_comb begin
    found     = 1'b0;
    pick_slot = ptr;
    pick_tid  = '0;
    for (int j = NUM_SLOTS - 1; j >= 0; j--) begin
      if (rot_hit[j]) begin
        found     = 1'b1;
        pick_slot = rot_slot[j];
        pick_tid  = rot_tid[j];
      end
    end
  end

endmodule

// File: rtl/hss_hub_ctrl.sv
module hss_hub_ctrl
  import hss_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int WIN_PERIOD  = 8,
  parameter int HUB_LAT     = 2,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int WIN_W = (WIN_PERIOD > 1) ? $clog2(WIN_PERIOD) : 1,
  localparam int LAT_W = $clog2(HUB_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TID_W-1:0] start_tid,
  output logic             busy,
  output logic             done,
  output logic [TID_W-1:0] done_tid
);

  hub_state_e       state, state_n;
  logic [WIN_W-1:0] win_cnt;
  logic [LAT_W-1:0] left, left_n;
  logic [TID_W-1:0] tid_q;
  logic             win_open;

  assign win_open = (win_cnt == '0);

  always_comb begin
    state_n = state;
    left_n  = left;
    unique case (state)
      HUB_IDLE: begin
        if (start) begin
          if (win_open) begin
            state_n = HUB_XFER;
            left_n  = LAT_W'(HUB_LAT);
          end else begin
            state_n = HUB_WAIT;
          end
        end
      end
      HUB_WAIT: begin
        if (win_open) begin
          state_n = HUB_XFER;
          left_n  = LAT_W'(HUB_LAT);
        end
      end
      HUB_XFER: begin
        if (left == LAT_W'(1)) state_n = HUB_IDLE;
        else                   left_n  = left - LAT_W'(1);
      end
      default: state_n = HUB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= HUB_IDLE;
      win_cnt <= '0;
      left    <= '0;
      tid_q   <= '0;
    end else begin
      state   <= state_n;
      left    <= left_n;
      win_cnt <= (win_cnt == WIN_W'(WIN_PERIOD - 1)) ? '0 : win_cnt + WIN_W'(1);
      if (start && state == HUB_IDLE) tid_q <= start_tid;
    end
  end

  assign busy     = (state != HUB_IDLE);
  assign done     = (state == HUB_XFER) && (left == LAT_W'(1));
  assign done_tid = tid_q;

endmodule

// File: rtl/hss_sched.sv
module hss_sched #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 16,
  parameter int WIN_PERIOD  = 8,
  parameter int HUB_LAT     = 2,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tbl_we,
  input  logic [SLOT_W-1:0]      tbl_addr,
  input  logic [TID_W-1:0]       tbl_tid,
  input  logic [NUM_THREADS-1:0] thr_valid,
  input  logic [NUM_THREADS-1:0] thr_hub,
  output logic                   issue_vld,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   issue_hub,
  output logic                   stall,
  output logic                   retire_vld,
  output logic [TID_W-1:0]       retire_tid
);

  logic [NUM_SLOTS*TID_W-1:0] entries_flat;
  logic [SLOT_W-1:0]          ptr, pick_slot, ptr_next;
  logic [TID_W-1:0]           pick_tid, hub_done_tid;
  logic                       found, hub_busy, hub_done;
  logic                       do_issue, do_hub;

  hss_slot_table #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (tbl_we),
    .wr_addr      (tbl_addr),
    .wr_tid       (tbl_tid),
    .entries_flat (entries_flat)
  );

  hss_slot_pick #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_pick (
    .entries_flat (entries_flat),
    .ptr          (ptr),
    .thr_valid    (thr_valid),
    .found        (found),
    .pick_slot    (pick_slot),
    .pick_tid     (pick_tid)
  );

  hss_hub_ctrl #(.NUM_THREADS(NUM_THREADS), .WIN_PERIOD(WIN_PERIOD),
                 .HUB_LAT(HUB_LAT)) u_hub (
    .clk       (clk),
    .rst       (rst),
    .start     (do_hub),
    .start_tid (pick_tid),
    .busy      (hub_busy),
    .done      (hub_done),
    .done_tid  (hub_done_tid)
  );

  // issue only when the shared pipeline is free
  assign do_issue = found && !hub_busy;
  assign do_hub   = do_issue && thr_hub[pick_tid];
  assign ptr_next = (pick_slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : pick_slot + SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      issue_vld  <= 1'b0;
      issue_tid  <= '0;
      issue_hub  <= 1'b0;
      stall      <= 1'b0;
      retire_vld <= 1'b0;
      retire_tid <= '0;
    end else begin
      if (do_issue) ptr <= ptr_next;
      issue_vld  <= do_issue;
      issue_tid  <= do_issue ? pick_tid : '0;
      issue_hub  <= do_hub;
      stall      <= hub_busy;
      retire_vld <= hub_done || (do_issue && !do_hub);
      retire_tid <= hub_done ? hub_done_tid :
                    ((do_issue && !do_hub) ? pick_tid : '0);
    end
  end

endmodule

// File: rtl/hss_sched_chk.sv
module hss_sched_chk #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_PERIOD  = 8,
  parameter int HUB_LAT     = 2,
  localparam int TID_W     = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int MAX_STALL = WIN_PERIOD + HUB_LAT - 1,
  localparam int RUN_W     = $clog2(MAX_STALL + 2) + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] thr_valid,
  input logic                   issue_vld,
  input logic [TID_W-1:0]       issue_tid,
  input logic                   issue_hub,
  input logic                   stall,
  input logic                   retire_vld,
  input logic [TID_W-1:0]       retire_tid
);

  logic [NUM_THREADS-1:0] past_valid;
  logic [RUN_W-1:0]       stall_run;

  always_ff @(posedge clk) begin
    past_valid <= thr_valid;
    if (rst)        stall_run <= '0;
    else if (stall) stall_run <= stall_run + RUN_W'(1);
    else            stall_run <= '0;
  end

  // R2
  issued_thread_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> past_valid[issue_tid]);

  // R7
  no_issue_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> !stall);

  // R5
  plain_retires_at_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !issue_hub) |-> (retire_vld && retire_tid == issue_tid));

  // R7
  hub_issue_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && issue_hub) |=> stall);

  // R7
  stall_holds_until_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !retire_vld) |=> stall);

  // R7
  stall_ends_after_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && retire_vld) |=> !stall);

  // R6
  stall_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    stall_run <= RUN_W'(MAX_STALL));

endmodule

bind hss_sched hss_sched_chk #(
  .NUM_THREADS (NUM_THREADS),
  .WIN_PERIOD  (WIN_PERIOD),
  .HUB_LAT     (HUB_LAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thr_valid  (thr_valid),
  .issue_vld  (issue_vld),
  .issue_tid  (issue_tid),
  .issue_hub  (issue_hub),
  .stall      (stall),
  .retire_vld (retire_vld),
  .retire_tid (retire_tid)
);

// File: tb/hss_sched_test.sv
module hss_sched_test;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int NS = 16;
  localparam int WP = 8;
  localparam int HL = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       tbl_we;
  logic [3:0] tbl_addr;
  logic [1:0] tbl_tid;
  logic [3:0] thr_valid, thr_hub;
  logic       issue_vld, issue_hub, stall, retire_vld;
  logic [1:0] issue_tid, retire_tid;

  always #(CLK_PERIOD/2) clk = ~clk;

  hss_sched uut (
    .clk (clk), .rst (rst), .tbl_we (tbl_we), .tbl_addr (tbl_addr),
    .tbl_tid (tbl_tid), .thr_valid (thr_valid), .thr_hub (thr_hub),
    .issue_vld (issue_vld), .issue_tid (issue_tid), .issue_hub (issue_hub),
    .stall (stall), .retire_vld (retire_vld), .retire_tid (retire_tid)
  );

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle model: memory ops tracked by remaining-cycle count
  int m_tbl [NS];
  int m_ptr, m_cnt, m_rem, m_htid;
  bit m_busy;
  bit e_iv, e_ih, e_st, e_rv;
  int e_it, e_rt;

  always @(posedge clk) begin : model
    int hit;
    if (rst) begin
      for (int i = 0; i < NS; i++) m_tbl[i] = i % NT;
      m_ptr = 0; m_cnt = 0; m_busy = 0; m_rem = 0; m_htid = 0;
      e_iv = 0; e_ih = 0; e_st = 0; e_rv = 0; e_it = 0; e_rt = 0;
    end else begin
      e_iv = 0; e_ih = 0; e_rv = 0; e_it = 0; e_rt = 0;
      e_st = m_busy;
      if (m_busy) begin
        if (m_rem == 1) begin
          e_rv = 1; e_rt = m_htid; m_busy = 0;
        end else begin
          m_rem--;
        end
      end else begin
        hit = -1;
        for (int i = 0; i < NS; i++) begin
          int s;
          s = (m_ptr + i) % NS;
          if (hit < 0 && thr_valid[m_tbl[s]]) hit = s;
        end
        if (hit >= 0) begin
          e_iv = 1; e_it = m_tbl[hit]; m_ptr = (hit + 1) % NS;
          if (thr_hub[e_it]) begin
            e_ih = 1; m_busy = 1; m_htid = e_it;
            m_rem = ((WP - m_cnt) % WP) + HL;
          end else begin
            e_rv = 1; e_rt = e_it;
          end
        end
      end
      if (tbl_we) m_tbl[tbl_addr] = tbl_tid;   // write lands after the scan (R9)
      m_cnt = (m_cnt + 1) % WP;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      check({issue_vld, issue_hub, issue_tid} == {e_iv, e_ih, e_it[1:0]}, "R2",
            "issue{vld,hub,tid}", int'({issue_vld, issue_hub, issue_tid}),
            int'({e_iv, e_ih, e_it[1:0]}));
      check(stall == e_st, "R7", "stall", int'(stall), int'(e_st));
      check({retire_vld, retire_tid} == {e_rv, e_rt[1:0]}, "R5",
            "retire{vld,tid}", int'({retire_vld, retire_tid}),
            int'({e_rv, e_rt[1:0]}));
    end
  end

  task automatic write_table(input bit weighted);
    thr_valid = '0; thr_hub = '0;
    for (int i = 0; i < NS; i++) begin
      tbl_we = 1'b1; tbl_addr = 4'(i);
      if (weighted) tbl_tid = (i % 4 == 3) ? 2'd2 : ((i % 4 == 1) ? 2'd0 : 2'd1);
      else          tbl_tid = 2'(i % NT);
      @(negedge clk);
    end
    tbl_we = 1'b0;
  endtask

  initial begin
    int cnt_t [NT];
    int cyc, first, rets;
    int ret_at [4];
    void'($urandom(32'd7731));
    rst = 1'b1; tbl_we = 1'b0; tbl_addr = '0; tbl_tid = '0;
    thr_valid = '0; thr_hub = '0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(!issue_vld && !issue_hub && !stall && !retire_vld &&
            issue_tid == 0 && retire_tid == 0, "R1", "outputs in reset",
            int'({issue_vld, issue_hub, stall, retire_vld, issue_tid, retire_tid}), 0);
    end
    rst = 1'b0; chk_en = 1'b1;
    thr_valid = 4'hF;

    // R1: default rotation, pointer from entry 0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(issue_vld && issue_tid == 2'(i % NT), "R1", "default order tid",
            int'(issue_tid), i % NT);
    end

    // R2: only thread 3 ready, skipped entries do not cost cycles
    thr_valid = 4'b1000;
    repeat (6) begin
      @(negedge clk);
      check(issue_vld && issue_tid == 2'd3, "R2", "skip to ready thread",
            int'({issue_vld, issue_tid}), 7);
    end
    thr_valid = 4'b0000;
    repeat (3) begin
      @(negedge clk);
      check(!issue_vld, "R2", "nothing ready", int'(issue_vld), 0);
    end

    // R3: pointer wrapped to 0 and held while idle
    thr_valid = 4'b0011;
    @(negedge clk);
    check(issue_vld && issue_tid == 2'd0, "R3", "pointer after wrap", int'(issue_tid), 0);
    @(negedge clk);
    check(issue_vld && issue_tid == 2'd1, "R3", "pointer advance", int'(issue_tid), 1);

    // R9: pointer now at entry 2; rewrite it while its old owner is ready
    thr_valid = 4'b0100; tbl_we = 1'b1; tbl_addr = 4'd2; tbl_tid = 2'd0;
    @(negedge clk);
    tbl_we = 1'b0; thr_valid = '0;
    check(issue_vld && issue_tid == 2'd2, "R9", "same-cycle write uses old entry",
          int'(issue_tid), 2);

    // R4: weighted pattern share
    write_table(1'b1);
    thr_valid = 4'b0111;
    for (int t = 0; t < NT; t++) cnt_t[t] = 0;
    repeat (64) begin
      @(negedge clk);
      if (issue_vld) cnt_t[issue_tid]++;
    end
    check(cnt_t[1] == 32, "R4", "thread 1 share", cnt_t[1], 32);
    check(cnt_t[0] == 16, "R4", "thread 0 share", cnt_t[0], 16);
    check(cnt_t[2] == 16, "R4", "thread 2 share", cnt_t[2], 16);

    // R8: four back-to-back memory ops, first one just past a window
    write_table(1'b0);
    do @(negedge clk); while (!(m_cnt == 1 && !m_busy));
    thr_valid = 4'hF; thr_hub = 4'hF;
    cyc = 0; first = -1; rets = 0;
    while (rets < 4 && cyc < 80) begin
      @(negedge clk);
      cyc++;
      if (issue_vld && first < 0) first = cyc;
      if (retire_vld) begin ret_at[rets] = cyc; rets++; end
    end
    thr_valid = '0; thr_hub = '0;
    check(rets == 4, "R8", "retire count", rets, 4);
    check(ret_at[0] - first + 1 == 10, "R6", "worst single latency",
          ret_at[0] - first + 1, 10);
    check(ret_at[1] - ret_at[0] == 8, "R8", "second gap", ret_at[1] - ret_at[0], 8);
    check(ret_at[3] - first + 1 == 34, "R8", "round length", ret_at[3] - first + 1, 34);

    // R6: memory op issued on the window takes 3 cycles
    do @(negedge clk); while (!(m_cnt == 0 && !m_busy));
    thr_valid = 4'b0001; thr_hub = 4'b0001;
    @(negedge clk);
    thr_valid = '0; thr_hub = '0;
    check(issue_vld && issue_hub && issue_tid == 0, "R6", "aligned issue",
          int'({issue_vld, issue_hub}), 3);
    @(negedge clk);
    check(stall && !retire_vld, "R7", "stall in access", int'({stall, retire_vld}), 2);
    @(negedge clk);
    check(retire_vld && retire_tid == 0, "R6", "aligned retire at third cycle",
          int'(retire_vld), 1);

    // random traffic with table writes, judged by the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      thr_valid = 4'($urandom);
      thr_hub   = 4'($urandom) & 4'($urandom);
      tbl_we    = ($urandom % 8) == 0;
      tbl_addr  = 4'($urandom);
      tbl_tid   = 2'($urandom);
    end
    @(negedge clk);
    tbl_we = 1'b0; thr_valid = '0; thr_hub = '0;
    repeat (12) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule